// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory. It runs on a fast system clock and oversamples the serial clock and data lines through synchronizers and glitch filters. It finds start and stop conditions and shifts in a device header and a word address. It answers with acknowledges by pulling the data line low through an output enable. Received data bytes go one at a time to an external write controller, and a commit pulse marks the end of a write burst.

Reads come from an attached array through a combinational read port addressed by a persistent pointer. The supported reads are current-address, random (a dummy write header followed by a repeated start) and sequential. While the write controller reports busy, the slave does not acknowledge its header, so the master can poll with header bytes. A parameter selects a 256-byte array with a three-bit select compare, or a 512-byte array in which one header bit is the word-address high bit.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the slave does not drive the data line (`sda_oe`=0), and `wr_en` and `wr_commit` are low.
- R2: A header byte is 1010 in bits 7..4, select bits in 3..1 and read/not-write in bit 0 (1 = read). The slave acknowledges (data line low during the ninth clock) only when the prefix matches and the select bits equal `sel_i`. On a mismatch it never drives and ignores the bus until the next start.
- R3: With ADDR_W=9, only header bits 3..2 are compared with `sel_i[2:1]`, and header bit 1 of a write header becomes word-address bit 8.
- R4: Each complete data byte of a write is acknowledged and issued as a one-cycle `wr_en` with `wr_addr`/`wr_data`. A stop or repeated start after at least one such byte gives a one-cycle `wr_commit`.
- R5: During a write, only the low PAGE_W address bits advance after each byte, wrapping to the start of the same page.
- R6: A write header plus a word address, then a repeated start and a read header, returns the byte at that address and writes nothing.
- R7: A read header with no word address returns the byte at the last accessed address plus one.
- R8: In a read, each master-acknowledged byte is followed by the next address, wrapping from the last array byte to 0. A master NACK ends the read and the slave releases the line.
- R9: While `wr_busy` is high the header byte gets no acknowledge. Once busy drops, the header is acknowledged again.
- R10: A start seen mid-byte abandons the transfer and restarts header reception. A partial data byte is never written.
- R11: `sda_oe` changes only while the filtered serial clock is low, apart from releases forced by a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock pad input |
| sda_i | input | 1 | Serial data pad input |
| sda_oe | output | 1 | 1 pulls the data line low |
| sel_i | input | 3 | Hardwired device select pins |
| rd_addr | output | ADDR_W | Read address to the array |
| rd_data | input | 8 | Array data at `rd_addr` |
| wr_en | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | ADDR_W | Array address of the byte |
| wr_data | output | 8 | Byte to write |
| wr_commit | output | 1 | One-cycle pulse that ends a write burst |
| wr_busy | input | 1 | Write controller busy with an internal cycle |

## Verification
The filtered lines lag the pads by about FILT_LEN+2 system cycles. The slave therefore changes `sda_oe` a few cycles after a serial-clock fall, and `wr_en` follows the fall after the eighth data bit by the same amount. The bench holds each serial-clock half period for 8 system cycles and samples the data line 4 cycles into the high phase, after every slave response has settled. Writes are confirmed by reading them back over the bus, not by cycle-exact strobes. The busy test issues its header right after the stop, so the eighth header bit falls well inside the 600-cycle busy window of the model.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR, ST_HDR_ACK, ST_WADR, ST_WADR_ACK,
        ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK
    } twi_state_e;
    localparam logic [3:0] HDR_PREFIX = 4'b1010;
endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1_q, s2_q, out_q, out_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        out_d = out_q;
        cnt_d = '0;
        if (s2_q != out_q) begin
            if (cnt_q == CW'(FILT_LEN - 1)) out_d = s2_q;
            else                            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 1'b1;
            s2_q  <= 1'b1;
            out_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            s1_q  <= raw_i;
            s2_q  <= s1_q;
            out_q <= out_d;
            cnt_q <= cnt_d;
        end
    end

    assign clean_o = out_q;
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_f;
            sda_p_q <= sda_f;
        end
    end

    assign scl_rise = !scl_p_q && scl_f;
    assign scl_fall = scl_p_q && !scl_f;
    assign start_ev = scl_p_q && scl_f && sda_p_q && !sda_f;
    assign stop_ev  = scl_p_q && scl_f && !sda_p_q && sda_f;
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int PAGE_W   = 3,
    parameter int FILT_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        sel_i,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    input  logic              wr_busy
);
    localparam bit         WIDE     = (ADDR_W > 8);
    localparam logic [2:0] SEL_MASK = WIDE ? 3'b110 : 3'b111;

    typedef struct packed {
        twi_state_e        state;
        logic [3:0]        bit_cnt;
        logic [7:0]        shift;
        logic [7:0]        tx;
        logic [ADDR_W-1:0] ptr;
        logic              oe;
        logic              rd;
        logic              hdr_hi;
        logic              wrote;
        logic              mack;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [7:0]        wr_data;
        logic              commit;
    } core_t;

    core_t r_q, r_d;

    // filtered pads: index 1 = clock, index 0 = data
    logic [1:0] raw_lines, clean_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        twi_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[g]), .clean_o(clean_lines[g])
        );
    end

    logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_f = clean_lines[1];
    assign sda_f = clean_lines[0];

    twi_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    logic              hdr_ok;
    logic [ADDR_W-1:0] load_addr, page_next;
    twi_state_e        state_q;

    assign hdr_ok    = (r_q.shift[7:4] == HDR_PREFIX) &&
                       (((r_q.shift[3:1] ^ sel_i) & SEL_MASK) == 3'b000);
    assign load_addr = ADDR_W'({r_q.hdr_hi, r_q.shift});
    assign page_next = {r_q.ptr[ADDR_W-1:PAGE_W], r_q.ptr[PAGE_W-1:0] + PAGE_W'(1)};
    assign state_q   = r_q.state;

    always_comb begin
        r_d        = r_q;
        r_d.wr_en  = 1'b0;
        r_d.commit = 1'b0;
        if (start_ev || stop_ev) begin
            r_d.state   = start_ev ? ST_HDR : ST_IDLE;
            r_d.bit_cnt = '0;
            r_d.oe      = 1'b0;
            r_d.commit  = r_q.wrote;
            r_d.wrote   = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_HDR, ST_WADR, ST_WDAT: begin
                    if (scl_rise) begin
                        r_d.shift   = {r_q.shift[6:0], sda_f};
                        r_d.bit_cnt = r_q.bit_cnt + 4'd1;
                    end else if (scl_fall && r_q.bit_cnt == 4'd8) begin
                        r_d.oe = 1'b1;
                        if (r_q.state == ST_HDR) begin
                            if (hdr_ok && !wr_busy) begin
                                r_d.state  = ST_HDR_ACK;
                                r_d.rd     = r_q.shift[0];
                                r_d.hdr_hi = WIDE && r_q.shift[1];
                            end else begin
                                r_d.state = ST_IDLE;
                                r_d.oe    = 1'b0;
                            end
                        end else if (r_q.state == ST_WADR) begin
                            r_d.ptr   = load_addr;
                            r_d.state = ST_WADR_ACK;
                        end else begin
                            r_d.wr_en   = 1'b1;
                            r_d.wr_addr = r_q.ptr;
                            r_d.wr_data = r_q.shift;
                            r_d.ptr     = page_next;
                            r_d.wrote   = 1'b1;
                            r_d.state   = ST_WDAT_ACK;
                        end
                    end
                end
                ST_HDR_ACK: begin
                    if (scl_fall) begin
                        r_d.bit_cnt = '0;
                        if (r_q.rd) begin
                            r_d.state = ST_RDAT;
                            r_d.tx    = rd_data;
                            r_d.oe    = !rd_data[7];
                        end else begin
                            r_d.state = ST_WADR;
                            r_d.oe    = 1'b0;
                        end
                    end
                end
                ST_WADR_ACK, ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        r_d.state   = ST_WDAT;
                        r_d.bit_cnt = '0;
                        r_d.oe      = 1'b0;
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        r_d.bit_cnt = r_q.bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (r_q.bit_cnt == 4'd8) begin
                            r_d.oe    = 1'b0;
                            r_d.ptr   = r_q.ptr + ADDR_W'(1);
                            r_d.state = ST_RACK;
                        end else begin
                            r_d.tx = {r_q.tx[6:0], 1'b0};
                            r_d.oe = !r_q.tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.mack = !sda_f;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.state   = ST_RDAT;
                            r_d.bit_cnt = '0;
                            r_d.tx      = rd_data;
                            r_d.oe      = !rd_data[7];
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_oe    = r_q.oe;
    assign rd_addr   = r_q.ptr;
    assign wr_en     = r_q.wr_en;
    assign wr_addr   = r_q.wr_addr;
    assign wr_data   = r_q.wr_data;
    assign wr_commit = r_q.commit;
endmodule

// File: rtl/twi_mem_chk.sv
module twi_mem_chk
    import twi_mem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       sda_oe,
    input logic       wr_en,
    input logic       wr_commit,
    input twi_state_e state_q
);
    // R11
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_f) || $past(start_ev) || $past(stop_ev)));

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R10
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state_q == ST_HDR));

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state_q == ST_IDLE));

    // R2
    hdr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR) |-> !sda_oe);
endmodule

bind twi_mem_slave twi_mem_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_commit(wr_commit), .state_q(state_q)
);

// File: tb/twi_mem_slave_test.sv
module twi_mem_slave_test;
    localparam int H = 8;
    localparam int BUSY_CYC = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic oe_a, oe_b;
    wire  sda_line = m_sda & ~oe_a & ~oe_b;

    logic [7:0] ra_a, wa_a, rd_a, wd_a, rd_b, wd_b;
    logic [8:0] ra_b, wa_b;
    logic we_a, we_b, cm_a, cm_b, busy_a, busy_b;
    int   bc_a, bc_b;
    logic [7:0] mem_a [256];
    logic [7:0] mem_b [512];
    logic [7:0] ref_a [256];
    logic [7:0] ref_b [512];
    int checks = 0, fails = 0, oe_viol = 0;
    bit done = 0;

    twi_mem_slave #(.ADDR_W(8), .PAGE_W(3), .FILT_LEN(2)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(oe_a),
        .sel_i(3'b101), .rd_addr(ra_a), .rd_data(rd_a), .wr_en(we_a), .wr_addr(wa_a),
        .wr_data(wd_a), .wr_commit(cm_a), .wr_busy(busy_a));

    twi_mem_slave #(.ADDR_W(9), .PAGE_W(4), .FILT_LEN(2)) uut_w (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(oe_b),
        .sel_i(3'b010), .rd_addr(ra_b), .rd_data(rd_b), .wr_en(we_b), .wr_addr(wa_b),
        .wr_data(wd_b), .wr_commit(cm_b), .wr_busy(busy_b));

    // array and write-controller models
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem_a[i] <= 8'h00;
            for (int i = 0; i < 512; i++) mem_b[i] <= 8'h00;
            bc_a <= 0;
            bc_b <= 0;
        end else begin
            if (we_a) mem_a[wa_a] <= wd_a;
            if (we_b) mem_b[wa_b] <= wd_b;
            if (cm_a) bc_a <= BUSY_CYC; else if (bc_a != 0) bc_a <= bc_a - 1;
            if (cm_b) bc_b <= BUSY_CYC; else if (bc_b != 0) bc_b <= bc_b - 1;
        end
    end
    assign busy_a = (bc_a != 0);
    assign busy_b = (bc_b != 0);
    assign rd_a = mem_a[ra_a];
    assign rd_b = mem_b[ra_b];

    // R11 monitor: slave outputs must not move while the serial clock is high
    logic oe_a_p = 1'b0, oe_b_p = 1'b0;
    always @(negedge clk) begin
        if (rst_n && m_scl && ((oe_a != oe_a_p) || (oe_b != oe_b_p))) oe_viol++;
        oe_a_p = oe_a;
        oe_b_p = oe_b;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_start();
        w(2); m_sda = 1'b1; w(H); m_scl = 1'b1; w(H); m_sda = 1'b0; w(H); m_scl = 1'b0;
    endtask

    task automatic t_stop();
        w(2); m_sda = 1'b0; w(H); m_scl = 1'b1; w(H); m_sda = 1'b1; w(H);
    endtask

    task automatic t_bit_out(input bit b);
        w(2); m_sda = b; w(H - 2); m_scl = 1'b1; w(H); m_scl = 1'b0;
    endtask

    task automatic t_bit_in(output bit b);
        w(2); m_sda = 1'b1; w(H - 2); m_scl = 1'b1; w(H / 2); b = sda_line;
        w(H - H / 2); m_scl = 1'b0;
    endtask

    task automatic t_send(input logic [7:0] v, output bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) t_bit_out(v[i]);
        t_bit_in(x);
        ack = !x;
    endtask

    task automatic t_recv(input bit give_ack, output logic [7:0] v);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            t_bit_in(x);
            v[i] = x;
        end
        t_bit_out(!give_ack);
    endtask

    function automatic logic [7:0] hdr(input bit wide, input int addr, input bit rd);
        if (wide) return 8'hA4 | (8'((addr >> 8) & 1) << 1) | 8'(rd);
        return 8'hAA | 8'(rd);
    endfunction

    function automatic int refv(input bit wide, input int a);
        return wide ? int'(ref_b[a]) : int'(ref_a[a]);
    endfunction

    // start + header, retried while the slave stays silent (busy polling)
    task automatic t_open(input bit wide, input int addr, input bit rd, output bit ok);
        bit ack;
        ok = 0;
        for (int t = 0; t < 40 && !ok; t++) begin
            t_start();
            t_send(hdr(wide, addr, rd), ack);
            if (ack) ok = 1;
            else     t_stop();
        end
    endtask

    task automatic write_seq(input bit wide, input int addr, input int n, input int base,
                             input string tag);
        bit ok, ack, all_ack;
        int a, pm;
        logic [7:0] v;
        pm = wide ? 15 : 7;
        t_open(wide, addr, 0, ok);
        chk(ok, {tag, " header ack"}, ok, 1);
        t_send(8'(addr), ack);
        all_ack = ack;
        a = addr;
        for (int k = 0; k < n; k++) begin
            v = 8'(base + k * 13);
            t_send(v, ack);
            all_ack &= ack;
            if (wide) ref_b[a] = v; else ref_a[a] = v;
            a = (a & ~pm) | ((a + 1) & pm);
        end
        chk(all_ack, {tag, " data acks"}, all_ack, 1);
        t_stop();
    endtask

    task automatic read_seq(input bit wide, input int addr, input bit random, input int n,
                            input string tag);
        bit ok, ack;
        int a, size;
        logic [7:0] v;
        size = wide ? 512 : 256;
        t_open(wide, addr, !random, ok);
        chk(ok, {tag, " header ack"}, ok, 1);
        if (random) begin
            t_send(8'(addr), ack);
            t_start();
            t_send(hdr(wide, addr, 1), ack);
            chk(ack, {tag, " read header ack"}, ack, 1);
        end
        a = addr;
        for (int k = 0; k < n; k++) begin
            t_recv(k != n - 1, v);
            chk(int'(v) == refv(wide, a), tag, v, refv(wide, a));
            a = (a + 1) % size;
        end
        t_stop();
    endtask

    initial begin
        bit ack, ok, exp;
        for (int i = 0; i < 256; i++) ref_a[i] = 8'h00;
        for (int i = 0; i < 512; i++) ref_b[i] = 8'h00;
        w(5);
        rst_n = 1'b1;
        w(2);
        // R1 reset state
        chk(!oe_a && !oe_b, "R1 sda_oe after reset", oe_a | oe_b, 0);
        chk(!we_a && !cm_a && !we_b && !cm_b, "R1 write strobes after reset", we_a | cm_a, 0);

        // R2 / R3 select sweep: small slave at 101, large slave at 01x
        for (int s = 0; s < 8; s++) begin
            t_start();
            t_send(8'hA0 | 8'(s << 1), ack);
            t_stop();
            exp = (s == 5) || (s == 2) || (s == 3);
            chk(ack == exp, (s == 2 || s == 3) ? "R3 select compare" : "R2 select compare",
                ack, exp);
        end
        t_start();
        t_send(8'h2A, ack);
        t_stop();
        chk(!ack, "R2 bad prefix", ack, 0);

        // R4 byte writes, then R6 random read and R7 current-address read
        write_seq(0, 'h90, 2, 'h5A, "R4");
        read_seq(0, 'h90, 1, 1, "R6 random read");
        read_seq(0, 'h91, 0, 1, "R7 current read");

        // R5 page wrap, followed at once by R9 busy header
        write_seq(0, 'h3E, 10, 'h40, "R5");
        t_start();
        t_send(8'hAA, ack);
        t_stop();
        chk(!ack, "R9 no ack while busy", ack, 0);
        t_open(0, 0, 0, ok);
        t_stop();
        chk(ok, "R9 ack after busy", ok, 1);
        read_seq(0, 'h38, 1, 8, "R5 page contents");
        read_seq(0, 'h40, 1, 1, "R5 next page untouched");

        // R10 start in the middle of a data byte
        t_open(0, 'h50, 0, ok);
        t_send(8'h50, ack);
        for (int i = 0; i < 4; i++) t_bit_out(1'b1);
        t_start();
        t_send(8'hAA, ack);
        t_stop();
        chk(ack, "R10 restart acked, no write cycle", ack, 1);
        read_seq(0, 'h50, 1, 1, "R10 partial byte not written");

        // R3 large array with page bit in the header, R8 wrap of the whole array
        write_seq(1, 'h1FE, 3, 'h21, "R3");
        read_seq(1, 'h1F0, 1, 1, "R3 page wrap");
        read_seq(1, 'h1FE, 1, 3, "R8 wrap large array");
        read_seq(0, 'hFE, 1, 1, "R3 small array untouched");

        // R8 exhaustive sweep of the small array
        for (int p = 0; p < 32; p++) write_seq(0, p * 8, 8, p * 29 + 1, "R8 sweep write");
        read_seq(0, 0, 1, 256, "R8 sequential sweep");
        read_seq(0, 0, 0, 1, "R7 pointer wrapped to 0");

        chk(oe_viol == 0, "R11 sda_oe stable while clock high", oe_viol, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule